// File: doc/BRIEF.md
# Multi-Class Interrupt Acceptance Controller

This block decides, once per clock, whether the CPU core takes an interrupt and which one. It arbitrates four classes of request, each with its own acceptance rules. The first is a pair of non-maskable sources: an external pin and a watchdog strobe. The second is a software trap with an operand-error strobe. The third is macro-service requests from sources that are set up for them. The fourth is ordinary maskable vectored requests, which carry a two-bit urgency level and nest.

The block keeps one pending flag for each request. It keeps a four-bit in-service vector (one bit per urgency level) for maskable nesting, and two in-service flags for the non-maskable sources. When a request wins, the block raises a one-cycle acknowledge carrying the source index and a kind code, and it clears that request's pending flag. The core signals that a service routine has finished with an end-of-service strobe. Vector fetch, context switching and the macro-service transfer itself are handled outside this block.

Top module: `irq_accept_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `ack_valid` is low, and no pending request or in-service state survives reset.
- R2: An unmasked maskable request with `glob_en` high and its `macro_en` bit clear is acknowledged exactly once. The acknowledge is a single-cycle `ack_valid` pulse with `ack_kind` = 0 (vectored) and `ack_src` = the source index. The kind codes are 0 vectored, 1 macro service, 2 non-maskable, 3 trap.
- R3: Among vectored requests that are eligible together, the lowest level number wins. Level 0 is the most urgent; source i's level is `irq_prio[2i+1:2i]`. Among requests at the same level, the lowest source index wins.
- R4: A source whose `irq_mask` bit is 1 is never acknowledged, as vectored or as macro service. Its pending flag is kept, and the source is acknowledged once the bit is cleared.
- R5: While `glob_en` is 0, no vectored request is acknowledged. Pending requests are kept and are accepted when `glob_en` returns to 1.
- R6: A vectored request is accepted only if its level is strictly more urgent than every level in service. A request at an equal or less urgent level waits. Accepting a request marks its level in service.
- R7: `eos` clears the most urgent in-service level when no non-maskable service is active. This releases requests that were waiting on that level.
- R8: A request from a source with `macro_en` set is acknowledged with kind 1, whatever the values of `glob_en` and the in-service levels. It leaves the in-service levels unchanged.
- R9: `trap_req` and `operr_req` are acknowledged with kind 3 even while `glob_en` is 0. The trap uses source 0 and the operand error uses source 1, and the trap goes first when both are pending.
- R10: A rising edge on `nmi_pin` is detected after a two-flop synchroniser and acknowledged with kind 2, source 0. A `wdt_nmi` strobe is acknowledged with kind 2, source 1. Neither depends on `glob_en`, and a pin held high triggers only once.
- R11: The pin NMI is not accepted while either NMI is in service. The watchdog NMI is not accepted while the watchdog NMI is in service, but it may nest over the pin NMI. No vectored request is accepted while any NMI is in service. `eos` during NMI service clears the watchdog flag if it is set, and otherwise clears the pin flag.
- R12: At most one acknowledge is issued per cycle, and the classes rank in this order: non-maskable, then trap, then macro service, then vectored.
- R13: Repeated strobes of a request before it is accepted produce a single acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | N_SRC | One-cycle request strobe for each maskable source |
| irq_mask | input | N_SRC | Per-source mask, where 1 blocks the source |
| irq_prio | input | 2*N_SRC | Two-bit level for each source, where 0 is the most urgent |
| macro_en | input | N_SRC | Per-source selection of macro service instead of vectored service |
| glob_en | input | 1 | Global enable for vectored maskable acceptance |
| nmi_pin | input | 1 | Asynchronous external non-maskable request, detected on its rising edge |
| wdt_nmi | input | 1 | Watchdog non-maskable request strobe |
| trap_req | input | 1 | Software trap strobe |
| operr_req | input | 1 | Operand-error strobe |
| eos | input | 1 | End-of-service strobe from the core |
| ack_valid | output | 1 | One-cycle acknowledge |
| ack_src | output | $clog2(N_SRC) | Index of the accepted source |
| ack_kind | output | 2 | Kind of acknowledge: 0 vectored, 1 macro, 2 NMI, 3 trap |

## Verification
The bench aims at the nesting boundary. A request at the same level as the active service must wait; a design that compared levels with "less than or equal" would acknowledge it at once. Other cases pair a simultaneous level tie with strobes that arrive together from several classes. A wrong tie-break or class order would show up as acknowledges out of order.

The non-maskable cases cover a pin edge that arrives while both NMIs are in service, and a watchdog that nests over the pin. A design that blocked the watchdog on the pin flag, or that cleared the wrong flag on end of service, would release requests early or never. Masked and globally disabled requests are later unmasked or re-enabled. This exposes a design that dropped the pending flag instead of holding it.

// File: rtl/irq_accept_pkg.sv
// Shared constants and types for the interrupt acceptance controller.
// Assumes exactly four urgency levels encoded in two bits.
package irq_accept_pkg;
    localparam int NUM_LVL = 4;
    localparam int LVL_W   = 2;

    typedef enum logic [1:0] {
        KIND_VEC   = 2'd0,
        KIND_MACRO = 2'd1,
        KIND_NMI   = 2'd2,
        KIND_TRAP  = 2'd3
    } ack_kind_e;
endpackage

// File: rtl/irq_first_pick.sv
// Fixed-order picker: reports whether any request bit is set and the
// index of the lowest set bit. Purely combinational; assumes N >= 2.
module irq_first_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so that the lowest set index is written last.
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_level_arb.sv
// Level arbiter for vectored requests: the lowest level number wins and
// the lowest index breaks ties inside a level. Assumes the eligibility
// vector has already been filtered by mask, enable and nesting state.
module irq_level_arb
    import irq_accept_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]       elig,
    input  logic [2*N-1:0]     prio,
    output logic               found,
    output logic [IW-1:0]      win_idx,
    output logic [LVL_W-1:0]   win_lvl
);
    logic [NUM_LVL-1:0] lvl_found;
    logic [IW-1:0]      lvl_idx [NUM_LVL];

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        logic [N-1:0] hit;

        // Collect eligible sources that sit at this level.
        always_comb begin
            for (int i = 0; i < N; i++) begin
                hit[i] = elig[i] && (prio[2*i +: LVL_W] == LVL_W'(l));
            end
        end

        irq_first_pick #(.N(N), .IW(IW)) u_pick (
            .req   (hit),
            .found (lvl_found[l]),
            .idx   (lvl_idx[l])
        );
    end

    // Take the most urgent level that has a candidate.
    always_comb begin
        found   = |lvl_found;
        win_idx = '0;
        win_lvl = '0;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (lvl_found[l]) begin
                win_idx = lvl_idx[l];
                win_lvl = LVL_W'(l);
            end
        end
    end
endmodule

// File: rtl/irq_isv_track.sv
// In-service tracker for maskable nesting: one bit per level. Setting a
// level marks it busy. End of service clears the most urgent busy level.
// lvl_open[l] is high when no level numbered l or lower is busy.
module irq_isv_track
    import irq_accept_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [LVL_W-1:0]   set_lvl,
    input  logic               clr_en,
    output logic [NUM_LVL-1:0] isv_q,
    output logic [NUM_LVL-1:0] lvl_open
);
    logic [NUM_LVL-1:0] clr_mask;
    logic [NUM_LVL-1:0] set_mask;

    // Select the most urgent busy level for clearing.
    always_comb begin
        clr_mask = '0;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (isv_q[l]) begin
                clr_mask    = '0;
                clr_mask[l] = clr_en;
            end
        end
    end

    // Decode the level that is being entered.
    always_comb begin
        set_mask = '0;
        set_mask[set_lvl] = set_en;
    end

    // Running "all more-urgent levels idle" chain.
    always_comb begin
        logic acc;
        acc = 1'b1;
        for (int l = 0; l < NUM_LVL; l++) begin
            acc         = acc & ~isv_q[l];
            lvl_open[l] = acc;
        end
    end

    // Update the in-service vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isv_q <= '0;
        end else begin
            isv_q <= (isv_q & ~clr_mask) | set_mask;
        end
    end
endmodule

// File: rtl/irq_nmi_unit.sv
// Non-maskable request unit. It synchronises the external pin, detects
// its rising edge, latches pending flags for the pin and the watchdog,
// and keeps one in-service flag for each. The watchdog ranks above the
// pin. Bit 1 of isv_q is the watchdog and bit 0 is the pin.
module irq_nmi_unit #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_async,
    input  logic       wdt_req,
    input  logic       take,
    input  logic       eos_in,
    output logic       go,
    output logic       sel_wdt,
    output logic [1:0] isv_q
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pin_rise;
    logic                   pend_pin_q;
    logic                   pend_wdt_q;
    logic                   go_pin;
    logic                   go_wdt;
    logic [1:0]             set_v;
    logic [1:0]             clr_v;

    // Bring the pin into the clock domain and remember the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign pin_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    // Acceptance: each source is blocked by itself or a higher-ranked source in service.
    assign go_wdt  = pend_wdt_q & ~isv_q[1];
    assign go_pin  = pend_pin_q & ~isv_q[1] & ~isv_q[0];
    assign go      = go_wdt | go_pin;
    assign sel_wdt = go_wdt;

    // In-service set on acceptance, clear of the innermost on end of service.
    always_comb begin
        set_v    = 2'b00;
        set_v[1] = take & sel_wdt;
        set_v[0] = take & ~sel_wdt;
        clr_v    = 2'b00;
        if (isv_q[1]) begin
            clr_v[1] = eos_in;
        end else begin
            clr_v[0] = eos_in;
        end
    end

    // Pending flags hold until accepted; a new event wins over a same-cycle accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_pin_q <= 1'b0;
            pend_wdt_q <= 1'b0;
            isv_q      <= 2'b00;
        end else begin
            pend_pin_q <= pin_rise | (pend_pin_q & ~set_v[0]);
            pend_wdt_q <= wdt_req  | (pend_wdt_q & ~set_v[1]);
            isv_q      <= (isv_q & ~clr_v) | set_v;
        end
    end
endmodule

// File: rtl/irq_accept_ctrl.sv
// Interrupt acceptance controller (top). It holds pending flags for the
// maskable sources and the trap pair, filters them by mask, global enable
// and nesting state, ranks the classes, and registers a one-cycle
// acknowledge. Assumes request strobes are synchronous to clk, except
// nmi_pin, which is synchronised inside.
module irq_accept_ctrl
    import irq_accept_pkg::*;
#(
    parameter int N_SRC       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_SRC-1:0]           irq_req,
    input  logic [N_SRC-1:0]           irq_mask,
    input  logic [2*N_SRC-1:0]         irq_prio,
    input  logic [N_SRC-1:0]           macro_en,
    input  logic                       glob_en,
    input  logic                       nmi_pin,
    input  logic                       wdt_nmi,
    input  logic                       trap_req,
    input  logic                       operr_req,
    input  logic                       eos,
    output logic                       ack_valid,
    output logic [$clog2(N_SRC)-1:0]   ack_src,
    output logic [1:0]                 ack_kind
);
    localparam int IDX_W = $clog2(N_SRC);

    logic [N_SRC-1:0]   pend_q;
    logic               trap_pend_q;
    logic               operr_pend_q;

    logic               nmi_go;
    logic               nmi_sel_wdt;
    logic [1:0]         nmi_isv;
    logic               nmi_busy;

    logic [N_SRC-1:0]   mac_elig;
    logic               mac_go;
    logic [IDX_W-1:0]   mac_idx;

    logic [NUM_LVL-1:0] isv_lvl;
    logic [NUM_LVL-1:0] lvl_open;
    logic [N_SRC-1:0]   vec_elig;
    logic               vec_go;
    logic [IDX_W-1:0]   vec_idx;
    logic [LVL_W-1:0]   vec_lvl;

    logic               take_nmi;
    logic               take_trap;
    logic               take_mac;
    logic               take_vec;
    logic [N_SRC-1:0]   ack_clr;
    logic [IDX_W-1:0]   src_d;
    ack_kind_e          kind_d;

    assign nmi_busy = |nmi_isv;

    irq_nmi_unit #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (nmi_pin),
        .wdt_req   (wdt_nmi),
        .take      (take_nmi),
        .eos_in    (eos & nmi_busy),
        .go        (nmi_go),
        .sel_wdt   (nmi_sel_wdt),
        .isv_q     (nmi_isv)
    );

    // Macro-service candidates ignore the global enable and nesting state.
    assign mac_elig = pend_q & ~irq_mask & macro_en;

    irq_first_pick #(.N(N_SRC), .IW(IDX_W)) u_mac_pick (
        .req   (mac_elig),
        .found (mac_go),
        .idx   (mac_idx)
    );

    // Vectored candidates must be enabled, unmasked and more urgent than all work in service.
    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            vec_elig[i] = pend_q[i] & ~irq_mask[i] & ~macro_en[i] & glob_en
                        & ~nmi_busy & lvl_open[irq_prio[2*i +: LVL_W]];
        end
    end

    irq_level_arb #(.N(N_SRC), .IW(IDX_W)) u_vec_arb (
        .elig    (vec_elig),
        .prio    (irq_prio),
        .found   (vec_go),
        .win_idx (vec_idx),
        .win_lvl (vec_lvl)
    );

    irq_isv_track u_isv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (take_vec),
        .set_lvl  (vec_lvl),
        .clr_en   (eos & ~nmi_busy),
        .isv_q    (isv_lvl),
        .lvl_open (lvl_open)
    );

    // Class ranking: NMI, then trap pair, then macro service, then vectored.
    always_comb begin
        take_nmi  = nmi_go;
        take_trap = ~nmi_go & (trap_pend_q | operr_pend_q);
        take_mac  = ~nmi_go & ~(trap_pend_q | operr_pend_q) & mac_go;
        take_vec  = ~nmi_go & ~(trap_pend_q | operr_pend_q) & ~mac_go & vec_go;
    end

    // Build the acknowledge contents and the pending clear vector.
    always_comb begin
        kind_d  = KIND_VEC;
        src_d   = '0;
        ack_clr = '0;
        if (take_nmi) begin
            kind_d = KIND_NMI;
            src_d  = nmi_sel_wdt ? IDX_W'(1) : IDX_W'(0);
        end else if (take_trap) begin
            kind_d = KIND_TRAP;
            src_d  = trap_pend_q ? IDX_W'(0) : IDX_W'(1);
        end else if (take_mac) begin
            kind_d           = KIND_MACRO;
            src_d            = mac_idx;
            ack_clr[mac_idx] = 1'b1;
        end else if (take_vec) begin
            kind_d           = KIND_VEC;
            src_d            = vec_idx;
            ack_clr[vec_idx] = 1'b1;
        end
    end

    // Pending flags: a new strobe wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q       <= '0;
            trap_pend_q  <= 1'b0;
            operr_pend_q <= 1'b0;
        end else begin
            pend_q       <= irq_req | (pend_q & ~ack_clr);
            trap_pend_q  <= trap_req | (trap_pend_q & ~take_trap);
            operr_pend_q <= operr_req | (operr_pend_q & ~(take_trap & ~trap_pend_q));
        end
    end

    // Register the acknowledge as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_src   <= '0;
            ack_kind  <= 2'd0;
        end else begin
            ack_valid <= take_nmi | take_trap | take_mac | take_vec;
            ack_src   <= src_d;
            ack_kind  <= kind_d;
        end
    end
endmodule

// File: rtl/irq_accept_chk.sv
// Checker for irq_accept_ctrl: relates the acknowledge to the inputs and
// state that were present in the cycle the decision was made.
module irq_accept_chk #(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               glob_en,
    input logic               eos,
    input logic [N_SRC-1:0]   irq_mask,
    input logic [2*N_SRC-1:0] irq_prio,
    input logic               ack_valid,
    input logic [IDX_W-1:0]   ack_src,
    input logic [1:0]         ack_kind,
    input logic [3:0]         isv_lvl,
    input logic [1:0]         nmi_isv
);
    function automatic logic [3:0] blockers(input logic [2*N_SRC-1:0] p,
                                            input logic [IDX_W-1:0] s);
        logic [1:0] lv;
        logic [3:0] m;
        lv = p[2*s +: 2];
        for (int k = 0; k < 4; k++) begin
            m[k] = (k <= int'(lv));
        end
        return m;
    endfunction

    // R1: the first cycle after reset carries no acknowledge.
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !ack_valid);

    // R5: vectored acknowledges only follow a cycle with the global enable set.
    assert_vec_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_kind == 2'd0) |-> $past(glob_en));

    // R4: masked sources are never acknowledged as vectored or macro.
    assert_masked_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_kind[1] == 1'b0) |-> !$past(irq_mask[ack_src]));

    // R6: a vectored source is strictly more urgent than every busy level.
    assert_strict_nesting_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_kind == 2'd0) |->
            (($past(isv_lvl) & blockers($past(irq_prio), ack_src)) == 4'd0));

    // R11: the pin NMI is accepted only when no NMI is in service.
    assert_pin_nmi_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_kind == 2'd2 && ack_src == '0) |-> ($past(nmi_isv) == 2'b00));

    // R11: the watchdog NMI is accepted only when its own service is idle.
    assert_wdt_nmi_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_kind == 2'd2 && ack_src != '0) |-> !$past(nmi_isv[1]));

    // R8: a macro-service acknowledge leaves the level state alone.
    assert_macro_keeps_levels_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_kind == 2'd1 && !$past(eos)) |-> (isv_lvl == $past(isv_lvl)));
endmodule

bind irq_accept_ctrl irq_accept_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glob_en   (glob_en),
    .eos       (eos),
    .irq_mask  (irq_mask),
    .irq_prio  (irq_prio),
    .ack_valid (ack_valid),
    .ack_src   (ack_src),
    .ack_kind  (ack_kind),
    .isv_lvl   (isv_lvl),
    .nmi_isv   (nmi_isv)
);

// File: tb/irq_accept_ctrl_bench.sv
// Scoreboard bench: stimulus tasks queue the acknowledges they expect and
// a negedge monitor pops and compares each acknowledge the design emits.
module irq_accept_ctrl_bench;
    localparam int N  = 8;
    localparam int IW = 3;
    localparam logic [1:0] K_VEC = 2'd0, K_MAC = 2'd1, K_NMI = 2'd2, K_TRP = 2'd3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N-1:0]   irq_req, irq_mask, macro_en;
    logic [2*N-1:0] irq_prio;
    logic           glob_en, nmi_pin, wdt_nmi, trap_req, operr_req, eos;
    logic           ack_valid;
    logic [IW-1:0]  ack_src;
    logic [1:0]     ack_kind;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";
    logic [1:0]    q_kind [$];
    logic [IW-1:0] q_src  [$];
    string         q_tag  [$];
    logic [1:0]    e_kind;
    logic [IW-1:0] e_src;
    string         e_tag;

    always #4 clk = ~clk;

    irq_accept_ctrl #(.N_SRC(N)) u_irq_accept_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_mask(irq_mask),
        .irq_prio(irq_prio), .macro_en(macro_en), .glob_en(glob_en),
        .nmi_pin(nmi_pin), .wdt_nmi(wdt_nmi), .trap_req(trap_req),
        .operr_req(operr_req), .eos(eos), .ack_valid(ack_valid),
        .ack_src(ack_src), .ack_kind(ack_kind)
    );

    // Monitor: every acknowledge must match the head of the expectation queue.
    always @(negedge clk) begin
        if (rst_n && ack_valid) begin
            checks++;
            if (q_kind.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected ack kind=%0d src=%0d, expected none",
                         cur_tag, ack_kind, ack_src);
            end else begin
                e_kind = q_kind.pop_front();
                e_src  = q_src.pop_front();
                e_tag  = q_tag.pop_front();
                if (ack_kind !== e_kind || ack_src !== e_src) begin
                    errors++;
                    $display("FAIL %s: ack kind=%0d src=%0d, expected kind=%0d src=%0d",
                             e_tag, ack_kind, ack_src, e_kind, e_src);
                end
            end
        end
    end

    task automatic expect_ack(input logic [1:0] k, input int s, input string tag);
        q_kind.push_back(k);
        q_src.push_back(IW'(s));
        q_tag.push_back(tag);
    endtask

    // Wait, then require that every queued acknowledge has arrived.
    task automatic settle(input int n, input string tag);
        repeat (n) @(negedge clk);
        #1;
        checks++;
        if (q_kind.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d ack(s) missing, next expected kind=%0d src=%0d, actual none",
                     tag, q_kind.size(), q_kind[0], q_src[0]);
            q_kind.delete();
            q_src.delete();
            q_tag.delete();
        end
    endtask

    task automatic pulse_req(input logic [N-1:0] v);
        @(negedge clk); irq_req = v;
        @(negedge clk); irq_req = '0;
    endtask

    task automatic pulse_eos();
        @(negedge clk); eos = 1'b1;
        @(negedge clk); eos = 1'b0;
    endtask

    task automatic pulse_wdt();
        @(negedge clk); wdt_nmi = 1'b1;
        @(negedge clk); wdt_nmi = 1'b0;
    endtask

    task automatic set_prio(input int i, input logic [1:0] l);
        @(negedge clk); irq_prio[2*i +: 2] = l;
    endtask

    // Watchdog: a hung run is reported as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung, expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_req = '0; irq_mask = '0; macro_en = '0;
        irq_prio = '1; glob_en = 1'b1; nmi_pin = 1'b0; wdt_nmi = 1'b0;
        trap_req = 1'b0; operr_req = 1'b0; eos = 1'b0;

        // R1: idle during reset and after release
        repeat (3) @(negedge clk);
        checks++;
        if (ack_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: ack_valid=%b during reset, expected 0", ack_valid);
        end
        @(negedge clk); rst_n = 1'b1;
        cur_tag = "R1";
        settle(4, "R1");

        // R2: single vectored request
        cur_tag = "R2";
        expect_ack(K_VEC, 5, "R2");
        pulse_req(8'b0010_0000);
        settle(5, "R2");
        pulse_eos();
        settle(3, "R2");

        // R3 / R7: level order and same-level tie on index
        cur_tag = "R3";
        set_prio(2, 2'd1); set_prio(6, 2'd1); set_prio(4, 2'd2);
        expect_ack(K_VEC, 2, "R3");
        pulse_req(8'b0101_0100);
        settle(5, "R3");
        expect_ack(K_VEC, 6, "R7");
        pulse_eos();
        settle(5, "R7");
        expect_ack(K_VEC, 4, "R7");
        pulse_eos();
        settle(5, "R7");
        pulse_eos();
        settle(3, "R7");

        // R6: strict nesting, equal and lower urgency wait
        cur_tag = "R6";
        set_prio(7, 2'd2); set_prio(0, 2'd3); set_prio(1, 2'd2); set_prio(3, 2'd0);
        expect_ack(K_VEC, 7, "R6");
        pulse_req(8'b1000_0000);
        settle(5, "R6");
        pulse_req(8'b0000_0011);
        settle(6, "R6");
        expect_ack(K_VEC, 3, "R6");
        pulse_req(8'b0000_1000);
        settle(5, "R6");
        pulse_eos();
        settle(5, "R7");
        expect_ack(K_VEC, 1, "R7");
        pulse_eos();
        settle(5, "R7");
        expect_ack(K_VEC, 0, "R7");
        pulse_eos();
        settle(5, "R7");
        pulse_eos();
        settle(3, "R7");

        // R4: masked source waits, then goes when unmasked
        cur_tag = "R4";
        @(negedge clk); irq_mask[3] = 1'b1;
        pulse_req(8'b0000_1000);
        settle(6, "R4");
        expect_ack(K_VEC, 3, "R4");
        @(negedge clk); irq_mask[3] = 1'b0;
        settle(5, "R4");
        pulse_eos();
        settle(3, "R4");

        // R5 / R13: global disable holds pending, repeated strobes give one ack
        cur_tag = "R5";
        @(negedge clk); glob_en = 1'b0;
        pulse_req(8'b0001_0000);
        pulse_req(8'b0001_0000);
        settle(6, "R5");
        expect_ack(K_VEC, 4, "R13");
        @(negedge clk); glob_en = 1'b1;
        settle(6, "R13");
        pulse_eos();
        settle(3, "R5");

        // R8: macro service bypasses enable and nesting, leaves levels alone
        cur_tag = "R8";
        set_prio(2, 2'd0); set_prio(6, 2'd3);
        expect_ack(K_VEC, 2, "R8");
        pulse_req(8'b0000_0100);
        settle(5, "R8");
        @(negedge clk); glob_en = 1'b0; macro_en[5] = 1'b1;
        expect_ack(K_MAC, 5, "R8");
        pulse_req(8'b0010_0000);
        settle(5, "R8");
        @(negedge clk); glob_en = 1'b1;
        pulse_req(8'b0100_0000);
        settle(6, "R8");
        expect_ack(K_VEC, 6, "R8");
        pulse_eos();
        settle(5, "R8");
        pulse_eos();
        settle(3, "R8");
        cur_tag = "R4";
        @(negedge clk); irq_mask[5] = 1'b1;
        pulse_req(8'b0010_0000);
        settle(6, "R4");
        expect_ack(K_MAC, 5, "R4");
        @(negedge clk); irq_mask[5] = 1'b0;
        settle(5, "R4");
        @(negedge clk); macro_en[5] = 1'b0;

        // R9: trap and operand error with global enable clear
        cur_tag = "R9";
        @(negedge clk); glob_en = 1'b0;
        expect_ack(K_TRP, 0, "R9");
        expect_ack(K_TRP, 1, "R9");
        @(negedge clk); trap_req = 1'b1; operr_req = 1'b1;
        @(negedge clk); trap_req = 1'b0; operr_req = 1'b0;
        settle(5, "R9");
        @(negedge clk); glob_en = 1'b1;

        // R10 / R11: pin edge, watchdog nesting, blocking and release order
        cur_tag = "R10";
        expect_ack(K_NMI, 0, "R10");
        @(negedge clk); nmi_pin = 1'b1;
        settle(8, "R10");
        expect_ack(K_NMI, 1, "R11");
        pulse_wdt();
        settle(5, "R11");
        cur_tag = "R11";
        @(negedge clk); nmi_pin = 1'b0;
        settle(5, "R11");
        @(negedge clk); nmi_pin = 1'b1;
        pulse_wdt();
        set_prio(3, 2'd3);
        pulse_req(8'b0000_1000);
        settle(8, "R11");
        expect_ack(K_NMI, 1, "R11");
        pulse_eos();
        settle(5, "R11");
        pulse_eos();
        settle(5, "R11");
        expect_ack(K_NMI, 0, "R11");
        pulse_eos();
        settle(5, "R11");
        expect_ack(K_VEC, 3, "R11");
        pulse_eos();
        settle(5, "R11");
        pulse_eos();
        settle(3, "R11");
        @(negedge clk); nmi_pin = 1'b0;
        settle(5, "R10");

        // R12: all classes in one cycle
        cur_tag = "R12";
        @(negedge clk); macro_en[1] = 1'b1; irq_prio[2*2 +: 2] = 2'd3;
        expect_ack(K_NMI, 1, "R12");
        expect_ack(K_TRP, 0, "R12");
        expect_ack(K_MAC, 1, "R12");
        @(negedge clk); wdt_nmi = 1'b1; trap_req = 1'b1; irq_req = 8'b0000_0110;
        @(negedge clk); wdt_nmi = 1'b0; trap_req = 1'b0; irq_req = '0;
        settle(6, "R12");
        expect_ack(K_VEC, 2, "R12");
        pulse_eos();
        settle(5, "R12");
        pulse_eos();
        settle(3, "R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule